// File: doc/BRIEF.md
# Dual-Stack Primitive Engine

This block holds the data stack and the return stack of a small stack processor and carries out one stack primitive per clock. There are six primitives: duplicate, drop, over, push to the return stack, pop from the return stack, and bitwise exclusive-OR of the top two data items. A separate literal strobe loads an 18-bit constant onto the data stack. The block has no swap opcode. To exchange the top two data items, the sequencer issues the six-step run over, push, over, xor, xor, pop. That run leaves both stacks at their original depth.

The top two data items live in registers, and so does the top return item. Deeper entries spill into an 8-entry ring for each stack. Each stack has a depth counter that raises a sticky overflow or underflow flag. The flags only report: the ring pointer wraps and the operation still completes.

Top module: `stack_core`

## Requirements
- R1: While rst_n is low at a clock edge, tos, nos and rtos become 0 and all four flags clear.
- R2: With lit_valid high, tos takes lit_data and nos takes the old tos. The literal wins over any opcode presented in the same cycle, and that opcode has no effect.
- R3: Opcode 3'd1 (duplicate) keeps tos and copies it into nos.
- R4: Opcode 3'd2 (drop) moves nos into tos and brings the third item up into nos.
- R5: Opcode 3'd3 (over) makes the old nos the new tos and the old tos the new nos, with the old nos also remaining third.
- R6: Opcode 3'd4 (push) moves tos into rtos, and the data stack drops by one.
- R7: Opcode 3'd5 (pop) moves rtos onto the data stack, and the return stack drops by one.
- R8: Opcode 3'd6 (xor) replaces the top two data items with their bitwise exclusive-OR.
- R9: Opcodes 3'd0 and 3'd7 with op_valid high change nothing. Any opcode with op_valid low changes nothing.
- R10: The sequence over, push, over, xor, xor, pop on a stack holding a on top of b leaves b on top of a, with rtos and both depths as before.
- R11: The data stack holds 10 items. A net push beyond that sets the sticky ds_over flag, and the ring wraps so the oldest item is lost.
- R12: A net pop from an empty data stack sets the sticky ds_under flag. Emptying the stack to exactly zero sets nothing.
- R13: The return stack holds 9 items. Its 10th net push sets the sticky rs_over flag, and a pop from an empty return stack sets the sticky rs_under flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 3 | Primitive select |
| lit_valid | input | 1 | Literal strobe, wins over op_valid |
| lit_data | input | 18 | Literal value |
| tos | output | 18 | Top data item |
| nos | output | 18 | Second data item |
| rtos | output | 18 | Top return item |
| ds_over | output | 1 | Sticky data-stack overflow |
| ds_under | output | 1 | Sticky data-stack underflow |
| rs_over | output | 1 | Sticky return-stack overflow |
| rs_under | output | 1 | Sticky return-stack underflow |

## Verification
Each primitive runs from a table of distinct operand values. Differing operands expose any mix-up between tos, nos and the third slot. The swap run uses two unequal values, which separates a true exchange from a duplicate, and it checks rtos afterwards to show the return stack is restored. Directed fills drive each ring past its capacity and then drain it. These runs distinguish the overflow and underflow thresholds by one item, and they show which item is lost after the ring wraps.

// File: rtl/stack_core_pkg.sv
// Shared constants and the opcode encoding for the stack engine.
// Assumes one primitive per clock; encodings are fixed by the sequencer.
package stack_core_pkg;
    localparam int unsigned WORD_W   = 18;
    localparam int unsigned RING_DEP = 8;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_DUP  = 3'd1,
        OP_DROP = 3'd2,
        OP_OVER = 3'd3,
        OP_PUSH = 3'd4,
        OP_POP  = 3'd5,
        OP_XOR  = 3'd6,
        OP_RSV  = 3'd7
    } op_e;
endpackage

// File: rtl/stack_ring.sv
// Circular spill store below the register-held stack top.
// Assumes DEPTH is a power of two and that push and pop never coincide.
// The pointer wraps freely; overflow policy belongs to the caller.
module stack_ring #(
    parameter int unsigned W     = 18,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] ptr;

    // Write on push, move the pointer on push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (push) begin
            mem[ptr] <= wdata;
            ptr      <= ptr + 1'b1;
        end else if (pop) begin
            ptr <= ptr - 1'b1;
        end
    end

    // Most recently written entry.
    assign top = mem[ptr - 1'b1];
endmodule

// File: rtl/depth_guard.sv
// Logical depth counter with sticky overflow and underflow flags.
// Assumes inc and dec are not both high. It saturates at 0 and CAP
// and flags the attempt instead of blocking it.
module depth_guard #(
    parameter int unsigned CAP = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic over_flag,
    output logic under_flag
);
    localparam int unsigned CW = $clog2(CAP + 1);
    localparam logic [CW-1:0] CAP_C = CW'(CAP);

    logic [CW-1:0] count;

    // Track depth and latch boundary violations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            over_flag  <= 1'b0;
            under_flag <= 1'b0;
        end else if (inc && !dec) begin
            if (count == CAP_C) over_flag <= 1'b1;
            else                count     <= count + 1'b1;
        end else if (dec && !inc) begin
            if (count == '0) under_flag <= 1'b1;
            else             count      <= count - 1'b1;
        end
    end
endmodule

// File: rtl/stack_core.sv
// Data stack plus return stack for a reduced-primitive stack machine.
// tos/nos and rtos are registers; deeper items spill to rings.
// Assumes a literal strobe takes priority over an opcode in the same cycle.
module stack_core
    import stack_core_pkg::*;
#(
    parameter int unsigned W     = WORD_W,
    parameter int unsigned DEPTH = RING_DEP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [2:0]   op_code,
    input  logic         lit_valid,
    input  logic [W-1:0] lit_data,
    output logic [W-1:0] tos,
    output logic [W-1:0] nos,
    output logic [W-1:0] rtos,
    output logic         ds_over,
    output logic         ds_under,
    output logic         rs_over,
    output logic         rs_under
);
    localparam int unsigned DS_CAP = DEPTH + 2;
    localparam int unsigned RS_CAP = DEPTH + 1;

    logic [W-1:0] tos_n, nos_n, rtos_n;
    logic [W-1:0] ds_third, rs_second;
    logic         ds_push, ds_pop, rs_push, rs_pop;
    op_e          op;

    assign op = op_e'(op_code);

    // Choose next register values and the ring moves for this cycle.
    always_comb begin
        tos_n   = tos;
        nos_n   = nos;
        rtos_n  = rtos;
        ds_push = 1'b0;
        ds_pop  = 1'b0;
        rs_push = 1'b0;
        rs_pop  = 1'b0;
        if (lit_valid) begin
            tos_n   = lit_data;
            nos_n   = tos;
            ds_push = 1'b1;
        end else if (op_valid) begin
            unique case (op)
                OP_DUP: begin
                    nos_n   = tos;
                    ds_push = 1'b1;
                end
                OP_DROP: begin
                    tos_n  = nos;
                    nos_n  = ds_third;
                    ds_pop = 1'b1;
                end
                OP_OVER: begin
                    tos_n   = nos;
                    nos_n   = tos;
                    ds_push = 1'b1;
                end
                OP_PUSH: begin
                    rtos_n  = tos;
                    rs_push = 1'b1;
                    tos_n   = nos;
                    nos_n   = ds_third;
                    ds_pop  = 1'b1;
                end
                OP_POP: begin
                    tos_n   = rtos;
                    nos_n   = tos;
                    ds_push = 1'b1;
                    rtos_n  = rs_second;
                    rs_pop  = 1'b1;
                end
                OP_XOR: begin
                    tos_n  = tos ^ nos;
                    nos_n  = ds_third;
                    ds_pop = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Register the visible stack tops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos  <= '0;
            nos  <= '0;
            rtos <= '0;
        end else begin
            tos  <= tos_n;
            nos  <= nos_n;
            rtos <= rtos_n;
        end
    end

    stack_ring #(.W(W), .DEPTH(DEPTH)) u_ds_ring (
        .clk(clk), .rst_n(rst_n), .push(ds_push), .pop(ds_pop),
        .wdata(nos), .top(ds_third)
    );

    stack_ring #(.W(W), .DEPTH(DEPTH)) u_rs_ring (
        .clk(clk), .rst_n(rst_n), .push(rs_push), .pop(rs_pop),
        .wdata(rtos), .top(rs_second)
    );

    depth_guard #(.CAP(DS_CAP)) u_ds_depth (
        .clk(clk), .rst_n(rst_n), .inc(ds_push), .dec(ds_pop),
        .over_flag(ds_over), .under_flag(ds_under)
    );

    depth_guard #(.CAP(RS_CAP)) u_rs_depth (
        .clk(clk), .rst_n(rst_n), .inc(rs_push), .dec(rs_pop),
        .over_flag(rs_over), .under_flag(rs_under)
    );
endmodule

// File: rtl/stack_core_chk.sv
// Port-level properties of the stack engine, bound to every instance.
// Assumes outputs are registered and the inputs are held across the edge.
module stack_core_chk #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [2:0]   op_code,
    input logic         lit_valid,
    input logic [W-1:0] lit_data,
    input logic [W-1:0] tos,
    input logic [W-1:0] nos,
    input logic [W-1:0] rtos,
    input logic         ds_over,
    input logic         rs_under
);
    // R2
    lit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lit_valid |=> (tos == $past(lit_data)) && (nos == $past(tos)));

    // R3
    dup_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lit_valid && op_valid && op_code == 3'd1)
        |=> (nos == $past(tos)) && (tos == $past(tos)));

    // R6
    push_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lit_valid && op_valid && op_code == 3'd4)
        |=> (rtos == $past(tos)) && (tos == $past(nos)));

    // R8
    xor_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lit_valid && op_valid && op_code == 3'd6)
        |=> tos == ($past(tos) ^ $past(nos)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lit_valid && !op_valid) |=> $stable(tos) && $stable(nos) && $stable(rtos));

    // R11
    ds_over_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ds_over |=> ds_over);

    // R13
    rs_under_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_under |=> rs_under);
endmodule

bind stack_core stack_core_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .lit_valid(lit_valid), .lit_data(lit_data), .tos(tos), .nos(nos),
    .rtos(rtos), .ds_over(ds_over), .rs_under(rs_under)
);

// File: tb/stack_core_tb.sv
// Self-checking bench: a vector table for the primitives and the swap run,
// then directed reset, overflow and underflow tests.
module stack_core_tb;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [2:0]   op_code = 3'd0;
    logic         lit_valid = 1'b0;
    logic [W-1:0] lit_data = '0;
    logic [W-1:0] tos, nos, rtos;
    logic         ds_over, ds_under, rs_over, rs_under;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    stack_core u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .lit_valid(lit_valid), .lit_data(lit_data), .tos(tos), .nos(nos),
        .rtos(rtos), .ds_over(ds_over), .ds_under(ds_under),
        .rs_over(rs_over), .rs_under(rs_under)
    );

    typedef struct packed {
        logic         lv;
        logic         ov;
        logic [2:0]   op;
        logic [17:0]  lit;
        logic [17:0]  et;
        logic [17:0]  en;
        logic [17:0]  er;
        logic [7:0]   req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 3'd0, 18'd5,  18'd5,  18'd0,  18'd0,  8'd2},  // R2 literal
        '{1'b1, 1'b0, 3'd0, 18'd9,  18'd9,  18'd5,  18'd0,  8'd2},  // R2 literal
        '{1'b0, 1'b1, 3'd1, 18'd0,  18'd9,  18'd9,  18'd0,  8'd3},  // R3 dup
        '{1'b0, 1'b1, 3'd2, 18'd0,  18'd9,  18'd5,  18'd0,  8'd4},  // R4 drop
        '{1'b0, 1'b1, 3'd3, 18'd0,  18'd5,  18'd9,  18'd0,  8'd5},  // R5 over
        '{1'b0, 1'b1, 3'd2, 18'd0,  18'd9,  18'd5,  18'd0,  8'd5},  // R5 third slot
        '{1'b0, 1'b1, 3'd4, 18'd0,  18'd5,  18'd0,  18'd9,  8'd6},  // R6 push
        '{1'b0, 1'b1, 3'd5, 18'd0,  18'd9,  18'd5,  18'd0,  8'd7},  // R7 pop
        '{1'b0, 1'b1, 3'd6, 18'd0,  18'd12, 18'd0,  18'd0,  8'd8},  // R8 xor
        '{1'b0, 1'b0, 3'd1, 18'd0,  18'd12, 18'd0,  18'd0,  8'd9},  // R9 not valid
        '{1'b0, 1'b1, 3'd0, 18'd0,  18'd12, 18'd0,  18'd0,  8'd9},  // R9 nop
        '{1'b0, 1'b1, 3'd7, 18'd0,  18'd12, 18'd0,  18'd0,  8'd9},  // R9 reserved
        '{1'b1, 1'b0, 3'd0, 18'd3,  18'd3,  18'd12, 18'd0,  8'd2},  // R2 literal
        '{1'b0, 1'b1, 3'd3, 18'd0,  18'd12, 18'd3,  18'd0,  8'd10}, // R10 over
        '{1'b0, 1'b1, 3'd4, 18'd0,  18'd3,  18'd12, 18'd12, 8'd10}, // R10 push
        '{1'b0, 1'b1, 3'd3, 18'd0,  18'd12, 18'd3,  18'd12, 8'd10}, // R10 over
        '{1'b0, 1'b1, 3'd6, 18'd0,  18'd15, 18'd12, 18'd12, 8'd10}, // R10 xor
        '{1'b0, 1'b1, 3'd6, 18'd0,  18'd3,  18'd0,  18'd12, 8'd10}, // R10 xor
        '{1'b0, 1'b1, 3'd5, 18'd0,  18'd12, 18'd3,  18'd0,  8'd10}, // R10 pop: swapped
        '{1'b1, 1'b1, 3'd2, 18'd7,  18'd7,  18'd12, 18'd0,  8'd2}   // R2 literal beats drop
    };

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, then return at the next falling edge.
    task automatic apply(input logic lv, input logic ov, input logic [2:0] op, input logic [W-1:0] lit);
        lit_valid = lv;
        op_valid  = ov;
        op_code   = op;
        lit_data  = lit;
        @(negedge clk);
        lit_valid = 1'b0;
        op_valid  = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 tos", tos, '0);
        check("R1 nos", nos, '0);
        check("R1 rtos", rtos, '0);
        check("R1 flags", {14'd0, ds_over, ds_under, rs_over, rs_under}, '0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].lv, VECS[i].ov, VECS[i].op, VECS[i].lit);
            check($sformatf("R%0d tos step %0d", VECS[i].req, i), tos, VECS[i].et);
            check($sformatf("R%0d nos step %0d", VECS[i].req, i), nos, VECS[i].en);
            check($sformatf("R%0d rtos step %0d", VECS[i].req, i), rtos, VECS[i].er);
        end
        // R12 no spurious flags after a balanced run
        check("R12 flags clear after table", {14'd0, ds_over, ds_under, rs_over, rs_under}, '0);

        // R11 data-stack capacity, wrap and R12 underflow threshold
        do_reset();
        for (int k = 1; k <= 10; k++) apply(1'b1, 1'b0, 3'd0, W'(k));
        check("R11 no overflow at 10", {17'd0, ds_over}, '0);
        apply(1'b1, 1'b0, 3'd0, 18'd11);
        check("R11 overflow at 11", {17'd0, ds_over}, 18'd1);
        for (int k = 0; k < 9; k++) apply(1'b0, 1'b1, 3'd2, '0);
        check("R11 newest kept after wrap", tos, 18'd2);
        apply(1'b0, 1'b1, 3'd2, '0);
        check("R12 no underflow at zero", {17'd0, ds_under}, '0);
        apply(1'b0, 1'b1, 3'd2, '0);
        check("R12 underflow set", {17'd0, ds_under}, 18'd1);
        apply(1'b1, 1'b0, 3'd0, 18'd4);
        check("R12 underflow sticky", {17'd0, ds_under}, 18'd1);
        check("R11 overflow sticky", {17'd0, ds_over}, 18'd1);

        // R13 return-stack capacity
        do_reset();
        for (int k = 1; k <= 9; k++) begin
            apply(1'b1, 1'b0, 3'd0, W'(k));
            apply(1'b0, 1'b1, 3'd4, '0);
        end
        check("R13 no overflow at 9", {17'd0, rs_over}, '0);
        apply(1'b1, 1'b0, 3'd0, 18'd10);
        apply(1'b0, 1'b1, 3'd4, '0);
        check("R13 overflow at 10", {17'd0, rs_over}, 18'd1);
        check("R13 rtos newest", rtos, 18'd10);
        check("R13 data stack unflagged", {16'd0, ds_over, ds_under}, '0);

        // R13 return-stack underflow
        do_reset();
        apply(1'b0, 1'b1, 3'd5, '0);
        check("R13 underflow set", {17'd0, rs_under}, 18'd1);

        // R1 reset clears flags and tops mid-run
        apply(1'b1, 1'b0, 3'd0, 18'd77);
        do_reset();
        check("R1 tos after rerun", tos, '0);
        check("R1 flags after rerun", {14'd0, ds_over, ds_under, rs_over, rs_under}, '0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule